// File: doc/BRIEF.md
# Firmware-Hub Cycle Target

This block sits on the peripheral side of an LPC bus and answers firmware-hub style memory cycles. It watches the 4-bit LAD nibble bus and the active-low frame strobe on the bus clock. When it sees a valid start code, it checks the hub-select nibble against a programmed value and gathers a full 32-bit address. A read cycle then waits through the host's turnaround, reports progress with SYNC codes while an internal memory fetches the byte, returns the byte as two nibbles and gives the bus back to the host. A write cycle takes the byte from the host before the turnaround, performs one internal write and acknowledges it with SYNC.

The internal side is a plain single-byte memory port. A one-clock read or write strobe goes out with a stable address, and the memory raises a ready flag when it has finished. The LAD bus is split into an input, an output and an output enable, so pad logic elsewhere can build the bidirectional pin. The hub-select value comes from the upper nibble of a configuration register held outside this block.

Top module: `fwh_target`

## Requirements
- R1: A cycle starts only on a clock where `frame_n` is low and `lad_in` is 4'b1101 (read) or 4'b1110 (write). Any other nibble under a low `frame_n` leaves the target idle: it does not drive LAD and raises no memory strobe.
- R2: The nibble after the start code must equal `hub_id`. If it does not, the target neither drives LAD nor strobes memory for the rest of that cycle.
- R3: The eight nibbles after the select nibble form `mem_addr`, most significant nibble first. The address holds steady while a memory access is in progress.
- R4: In a read, the host drives two turnaround clocks after the address, and then the target drives SYNC. `mem_rd` is high for exactly one clock, the first SYNC clock. `mem_rd` and `mem_wr` are never high together.
- R5: While the access is pending, the target drives 4'b0101 on the first SHORT_WAITS SYNC clocks and 4'b0110 on every later one. Once 4'b0110 has appeared, 4'b0101 does not return. Each strobe is followed by at least one more wait clock, and one clock after `mem_ready` is sampled high the target drives 4'b0000 for a single clock.
- R6: In a read, the byte follows the 4'b0000 SYNC as bits 3..0 on the first clock and bits 7..4 on the second.
- R7: The target drives 4'b1111 for one clock after the data (read) or after the SYNC (write), releases `lad_oe` on the next clock and can then accept a new cycle.
- R8: In a write, the host supplies bits 3..0 and then bits 7..4 right after the address, and the target does not drive LAD while it does so. After two host turnaround clocks, `mem_wr` pulses once with that byte on `mem_wdata`.
- R9: A low `frame_n` in the middle of a cycle without a start code abandons the cycle. No drive and no strobe follow. A low `frame_n` with a start code begins a fresh cycle.
- R10: During and just after reset, and on any clock outside its own bus phases, `lad_oe`, `mem_rd` and `mem_wr` are low. Reset asserted mid-cycle takes effect at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | LPC bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame strobe from the host, active low |
| lad_in | input | 4 | LAD nibble as seen on the bus |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | High while the target drives LAD |
| hub_id | input | 4 | Hub-select value (upper nibble of the configuration register) |
| mem_addr | output | ADDR_W | Address of the internal access |
| mem_rd | output | 1 | One-clock read strobe |
| mem_wr | output | 1 | One-clock write strobe |
| mem_wdata | output | DATA_W | Byte to write |
| mem_rdata | input | DATA_W | Byte read, valid while mem_ready is high |
| mem_ready | input | 1 | Internal access complete |

## Verification
The assertions assume that the memory raises `mem_ready` only after a strobe and keeps `mem_rdata` valid while the flag is high. They also assume that `hub_id` does not change inside a cycle. The bench memory model raises ready a set number of clocks after each strobe and clears it once it has been sampled, so the wait-code sequence always depends on a known latency. The host tasks change `frame_n` and `lad_in` only on falling edges, keep LAD at 4'b1111 whenever the host is not driving, and abandon cycles only by pulling the frame strobe low.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEL,
      ST_ADDR,
      ST_DATA,
      ST_HTAR1,
      ST_HTAR2,
      ST_SYNC,
      ST_SYNC_OK,
      ST_TTAR1,
      ST_TTAR2
   } fwh_state_e;

   localparam logic [3:0] CODE_RD_START = 4'b1101;
   localparam logic [3:0] CODE_WR_START = 4'b1110;
   localparam logic [3:0] SYNC_DONE     = 4'b0000;
   localparam logic [3:0] SYNC_SHORT    = 4'b0101;
   localparam logic [3:0] SYNC_LONG     = 4'b0110;
   localparam logic [3:0] LAD_PARK      = 4'b1111;

endpackage

// File: rtl/fwh_addr_shift.sv
// Nibble-wide shift register; the most significant nibble arrives first.
module fwh_addr_shift #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic [3:0]        nib_in,
   output logic [ADDR_W-1:0] addr_out
);

   generate
      if (ADDR_W % 4 != 0 || ADDR_W < 8) begin : g_bad_width
         $error("fwh_addr_shift: ADDR_W must be a multiple of 4, at least 8");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_out <= '0;
      end else if (shift_en) begin
         addr_out <= {addr_out[ADDR_W-5:0], nib_in};
      end
   end

endmodule

// File: rtl/fwh_wait_gen.sv
// Counts SYNC clocks and picks the short or long wait code.
module fwh_wait_gen
   import fwh_pkg::*;
#(
   parameter int SHORT_WAITS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   output logic       first,
   output logic [3:0] code
);

   localparam int CW = (SHORT_WAITS < 1) ? 1 : $clog2(SHORT_WAITS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(SHORT_WAITS);

   generate
      if (SHORT_WAITS < 1) begin : g_bad_waits
         $error("fwh_wait_gen: SHORT_WAITS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!active) begin
         cnt <= '0;
      end else if (cnt != LIMIT) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign first = (cnt == '0);
   assign code  = (cnt < LIMIT) ? SYNC_SHORT : SYNC_LONG;

endmodule

// File: rtl/fwh_lad_mux.sv
// Chooses what the target places on LAD in each state.
module fwh_lad_mux
   import fwh_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input  fwh_state_e        state,
   input  logic              is_wr,
   input  logic [DATA_W-1:0] rdata,
   input  logic [CNT_W-1:0]  nib_idx,
   input  logic [3:0]        wait_code,
   output logic              oe,
   output logic [3:0]        nib_out
);

   logic [3:0] data_nib;
   assign data_nib = rdata[{nib_idx, 2'b00} +: 4];

   always_comb begin
      oe      = 1'b0;
      nib_out = LAD_PARK;
      case (state)
         ST_SYNC: begin
            oe      = 1'b1;
            nib_out = wait_code;
         end
         ST_SYNC_OK: begin
            oe      = 1'b1;
            nib_out = SYNC_DONE;
         end
         ST_DATA: begin
            oe      = !is_wr;
            nib_out = data_nib;
         end
         ST_TTAR1: begin
            oe      = 1'b1;
            nib_out = LAD_PARK;
         end
         default: begin
            oe      = 1'b0;
            nib_out = LAD_PARK;
         end
      endcase
   end

endmodule

// File: rtl/fwh_target.sv
module fwh_target
   import fwh_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 8,
   parameter int SHORT_WAITS  = 4,
   parameter bit ENABLE_WRITE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        lad_in,
   output logic [3:0]        lad_out,
   output logic              lad_oe,
   input  logic [3:0]        hub_id,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);

   localparam int ADDR_NIB = ADDR_W / 4;
   localparam int DATA_NIB = DATA_W / 4;
   localparam int MAX_NIB  = (ADDR_NIB > DATA_NIB) ? ADDR_NIB : DATA_NIB;
   localparam int CNT_W    = (MAX_NIB < 2) ? 1 : $clog2(MAX_NIB);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIB - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIB - 1);

   generate
      if (DATA_W % 4 != 0 || DATA_W < 4) begin : g_bad_data
         $error("fwh_target: DATA_W must be a positive multiple of 4");
      end
      if (ADDR_W % 4 != 0 || ADDR_W < 8) begin : g_bad_addr
         $error("fwh_target: ADDR_W must be a multiple of 4, at least 8");
      end
   endgenerate

   fwh_state_e        state;
   logic              is_wr;
   logic [CNT_W-1:0]  nib_cnt;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] wdata_q;
   logic              wr_start;
   logic              wait_first;
   logic [3:0]        wait_code;
   logic              shift_en;

   // Write support is optional; without it only the read start code counts.
   generate
      if (ENABLE_WRITE) begin : g_wr
         assign wr_start = (lad_in == CODE_WR_START);
         assign mem_wr   = (state == ST_SYNC) && is_wr && wait_first;
      end else begin : g_rd_only
         assign wr_start = 1'b0;
         assign mem_wr   = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_wr   <= 1'b0;
         nib_cnt <= '0;
         rdata_q <= '0;
         wdata_q <= '0;
      end else if (!frame_n) begin
         // A low frame strobe always restarts decoding, whatever the state.
         nib_cnt <= '0;
         if (lad_in == CODE_RD_START) begin
            state <= ST_SEL;
            is_wr <= 1'b0;
         end else if (wr_start) begin
            state <= ST_SEL;
            is_wr <= 1'b1;
         end else begin
            state <= ST_IDLE;
         end
      end else begin
         case (state)
            ST_IDLE: state <= ST_IDLE;
            ST_SEL: state <= (lad_in == hub_id) ? ST_ADDR : ST_IDLE;
            ST_ADDR: begin
               if (nib_cnt == ADDR_LAST) begin
                  nib_cnt <= '0;
                  state   <= is_wr ? ST_DATA : ST_HTAR1;
               end else begin
                  nib_cnt <= nib_cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (is_wr) begin
                  wdata_q[{nib_cnt, 2'b00} +: 4] <= lad_in;
               end
               if (nib_cnt == DATA_LAST) begin
                  nib_cnt <= '0;
                  state   <= is_wr ? ST_HTAR1 : ST_TTAR1;
               end else begin
                  nib_cnt <= nib_cnt + 1'b1;
               end
            end
            ST_HTAR1: state <= ST_HTAR2;
            ST_HTAR2: state <= ST_SYNC;
            ST_SYNC: begin
               if (mem_ready) begin
                  state <= ST_SYNC_OK;
                  if (!is_wr) begin
                     rdata_q <= mem_rdata;
                  end
               end
            end
            ST_SYNC_OK: begin
               nib_cnt <= '0;
               state   <= is_wr ? ST_TTAR1 : ST_DATA;
            end
            ST_TTAR1: state <= ST_TTAR2;
            ST_TTAR2: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign shift_en  = frame_n && (state == ST_ADDR);
   assign mem_rd    = (state == ST_SYNC) && !is_wr && wait_first;
   assign mem_wdata = wdata_q;

   fwh_addr_shift #(
      .ADDR_W(ADDR_W)
   ) i_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .nib_in  (lad_in),
      .addr_out(mem_addr)
   );

   fwh_wait_gen #(
      .SHORT_WAITS(SHORT_WAITS)
   ) i_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .active(state == ST_SYNC),
      .first (wait_first),
      .code  (wait_code)
   );

   fwh_lad_mux #(
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
   ) i_mux (
      .state    (state),
      .is_wr    (is_wr),
      .rdata    (rdata_q),
      .nib_idx  (nib_cnt),
      .wait_code(wait_code),
      .oe       (lad_oe),
      .nib_out  (lad_out)
   );

endmodule

// File: rtl/fwh_target_chk.sv
module fwh_target_chk
   import fwh_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic [3:0]        lad_in,
   input logic [3:0]        lad_out,
   input logic              lad_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr
);

   p_excl_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   p_strobe_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (lad_oe && lad_out == SYNC_SHORT));

   p_long_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lad_oe && lad_out == SYNC_LONG) |=> (!lad_oe || lad_out != SYNC_SHORT));

   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |=> $stable(mem_addr));

   p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n && lad_in != CODE_RD_START && lad_in != CODE_WR_START)
      |=> (!lad_oe && !mem_rd && !mem_wr));

endmodule

bind fwh_target fwh_target_chk #(
   .ADDR_W(ADDR_W)
) i_fwh_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .frame_n (frame_n),
   .lad_in  (lad_in),
   .lad_out (lad_out),
   .lad_oe  (lad_oe),
   .mem_addr(mem_addr),
   .mem_rd  (mem_rd),
   .mem_wr  (mem_wr)
);

// File: tb/test_fwh_target.sv
module test_fwh_target;

   localparam int         SHORT  = 4;
   localparam logic [3:0] MY_SEL = 4'h9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  lad_in = 4'hF;
   logic [3:0]  lad_out;
   logic        lad_oe;
   logic [31:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        mem_ready;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   fwh_target #(
      .ADDR_W(32), .DATA_W(8), .SHORT_WAITS(SHORT), .ENABLE_WRITE(1'b1)
   ) i_fwh_target (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
      .lad_out(lad_out), .lad_oe(lad_oe), .hub_id(MY_SEL),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   // Bench memory: ready comes lat+1 clocks after a strobe.
   function automatic logic [7:0] memf(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   int          lat = 0;
   logic        pend = 1'b0;
   int          mcnt = 0;
   int          rd_cnt = 0, wr_cnt = 0, oe_cnt = 0;
   logic [31:0] cap_addr = '0;
   logic [7:0]  cap_wdata = '0;

   assign mem_ready = pend && (mcnt == 0);
   assign mem_rdata = memf(mem_addr);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         mcnt <= 0;
      end else begin
         if (lad_oe) oe_cnt <= oe_cnt + 1;
         if (mem_rd || mem_wr) begin
            pend     <= 1'b1;
            mcnt     <= lat;
            cap_addr <= mem_addr;
            if (mem_rd) rd_cnt <= rd_cnt + 1;
            if (mem_wr) begin
               wr_cnt    <= wr_cnt + 1;
               cap_wdata <= mem_wdata;
            end
         end else if (pend) begin
            if (mcnt == 0) pend <= 1'b0;
            else mcnt <= mcnt - 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic f, input logic [3:0] d);
      @(negedge clk);
      frame_n = f;
      lad_in  = d;
   endtask

   task automatic header(input logic [3:0] st, input logic [3:0] sel,
                         input logic [31:0] a);
      drive(1'b0, st);
      drive(1'b1, sel);
      for (int i = 7; i >= 0; i--) drive(1'b1, a[i*4 +: 4]);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b1, 4'hF);
   endtask

   // Observes the target phases; first sample is the first SYNC clock.
   task automatic collect(input bit wr, input logic [7:0] exp_data, input int waits);
      int  w = 0;
      bit  codes_ok = 1'b1;
      @(negedge clk);
      while (lad_oe && (lad_out == 4'h5 || lad_out == 4'h6) && w < 40) begin
         if (lad_out != ((w < SHORT) ? 4'h5 : 4'h6)) codes_ok = 1'b0;
         w++;
         @(negedge clk);
      end
      chk(codes_ok, "R5 wait code order", 32'(codes_ok), 32'd1);
      chk(w == waits, "R5 wait clock count", 32'(w), 32'(waits));
      chk(lad_oe && lad_out == 4'h0, "R5 ready sync", {lad_oe, lad_out}, 32'h10);
      if (!wr) begin
         @(negedge clk);
         chk(lad_oe && lad_out == exp_data[3:0], "R6 low nibble",
             {lad_oe, lad_out}, {1'b1, exp_data[3:0]});
         @(negedge clk);
         chk(lad_oe && lad_out == exp_data[7:4], "R6 high nibble",
             {lad_oe, lad_out}, {1'b1, exp_data[7:4]});
      end
      @(negedge clk);
      chk(lad_oe && lad_out == 4'hF, "R7 park nibble", {lad_oe, lad_out}, 32'h1F);
      @(negedge clk);
      chk(!lad_oe, "R7 release", 32'(lad_oe), 32'd0);
   endtask

   task automatic do_read(input logic [31:0] a, input int l);
      int rd0 = rd_cnt;
      lat = l;
      header(4'hD, MY_SEL, a);
      drive(1'b1, 4'hF);
      drive(1'b1, 4'hF);
      collect(1'b0, memf(a), l + 2);
      chk(rd_cnt == rd0 + 1, "R4 one read strobe", 32'(rd_cnt - rd0), 32'd1);
      chk(cap_addr == a, "R3 address", cap_addr, a);
   endtask

   task automatic do_write(input logic [31:0] a, input logic [7:0] d, input int l);
      int wr0 = wr_cnt;
      int oe0;
      lat = l;
      header(4'hE, MY_SEL, a);
      oe0 = oe_cnt;
      drive(1'b1, d[3:0]);
      drive(1'b1, d[7:4]);
      drive(1'b1, 4'hF);
      drive(1'b1, 4'hF);
      chk(oe_cnt == oe0, "R8 no drive in host data", 32'(oe_cnt - oe0), 32'd0);
      collect(1'b1, 8'h00, l + 2);
      chk(wr_cnt == wr0 + 1, "R8 one write strobe", 32'(wr_cnt - wr0), 32'd1);
      chk(cap_wdata == d, "R8 write data", 32'(cap_wdata), 32'(d));
      chk(cap_addr == a, "R3 write address", cap_addr, a);
   endtask

   // {write, address, data, latency}
   localparam logic [44:0] VECS [6] = '{
      {1'b0, 32'h0000_0000, 8'h00, 4'd0},
      {1'b0, 32'hFFBC_1234, 8'h00, 4'd1},
      {1'b1, 32'h0010_00A5, 8'hC3, 4'd0},
      {1'b0, 32'h8765_4321, 8'h00, 4'd3},
      {1'b1, 32'hDEAD_BEEF, 8'h0F, 4'd5},
      {1'b0, 32'h0001_7F80, 8'h00, 4'd2}
   };

   initial begin
      int rd0, wr0, oe0;
      repeat (3) @(negedge clk);
      chk(!lad_oe && !mem_rd && !mem_wr, "R10 quiet in reset",
          {lad_oe, mem_rd, mem_wr}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!lad_oe && !mem_rd && !mem_wr, "R10 quiet after reset",
          {lad_oe, mem_rd, mem_wr}, 32'd0);

      for (int i = 0; i < 6; i++) begin
         if (VECS[i][44]) do_write(VECS[i][43:12], VECS[i][11:4], int'(VECS[i][3:0]));
         else do_read(VECS[i][43:12], int'(VECS[i][3:0]));
      end

      // R5: long latency, four short then long waits
      do_read(32'h1357_9BDF, 7);

      // R1: unknown start code ignored
      rd0 = rd_cnt; wr0 = wr_cnt; oe0 = oe_cnt;
      header(4'hC, MY_SEL, 32'h0000_0011);
      idle(12);
      chk(rd_cnt == rd0 && wr_cnt == wr0 && oe_cnt == oe0, "R1 bad start ignored",
          32'(oe_cnt - oe0), 32'd0);

      // R2: select mismatch ignored
      rd0 = rd_cnt; oe0 = oe_cnt;
      header(4'hD, ~MY_SEL, 32'h0000_0022);
      idle(12);
      chk(rd_cnt == rd0 && oe_cnt == oe0, "R2 select mismatch ignored",
          32'(oe_cnt - oe0), 32'd0);

      // R9: abort mid-address with no start code
      rd0 = rd_cnt; oe0 = oe_cnt;
      drive(1'b0, 4'hD); drive(1'b1, MY_SEL);
      drive(1'b1, 4'h1); drive(1'b1, 4'h2); drive(1'b1, 4'h3);
      drive(1'b0, 4'hF);
      idle(16);
      chk(rd_cnt == rd0 && oe_cnt == oe0, "R9 abort quiet",
          32'(oe_cnt - oe0), 32'd0);

      // R9: fresh start mid-address restarts the cycle
      drive(1'b0, 4'hD); drive(1'b1, MY_SEL); drive(1'b1, 4'h4); drive(1'b1, 4'h5);
      do_read(32'hA5A5_0F0F, 1);

      // R7: back-to-back cycle right after release
      do_write(32'h0000_00FF, 8'h5A, 2);

      // R10: reset during SYNC
      lat = 20;
      header(4'hD, MY_SEL, 32'h0000_0033);
      drive(1'b1, 4'hF); drive(1'b1, 4'hF);
      repeat (3) @(negedge clk);
      chk(lad_oe, "R4 driving before reset", 32'(lad_oe), 32'd1);
      rst_n = 1'b0;
      #1;
      chk(!lad_oe && !mem_rd, "R10 reset mid-cycle", {lad_oe, mem_rd}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      do_read(32'h0000_0044, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule